// File: doc/BRIEF.md
# Range-Decoded External Bus Controller

This block sits between a 16-bit processor core and an external memory bus. Every access address is compared against five programmable address windows. The window that claims an access selects its own chip select, its own number of wait states and its own bus timing mode. The choice is made once, when the request is accepted, and it holds for the whole access. An address that no window claims goes to a spare chip select with the slowest timing.

The external data path carries one 16-bit word per bus cycle. A 32-bit request therefore runs as two word cycles back to back. The low word is at the given address and the high word is at the address plus two. The core raises a level request, holds its inputs stable, and sees a one-cycle ready pulse when the whole access is done.

An external master can ask for the bus on a hold input. The controller finishes any access in flight, including both words of a split access. It then acknowledges and stops driving address, data, strobes and chip selects until hold drops.

Top module: `ebc_top`

## Requirements
- R1: A window is programmed through the configuration port. cfg_kind 0 writes the base, 1 writes the mask and 2 writes the control word: bits [3:0] wait states, [5:4] mode, [6] enable. An access matches an enabled window when the address equals the base in every bit where the mask is 1.
- R2: Chip selects are active low. During an access exactly one select is low, and it is the one belonging to the selected window. Bit 5 is the spare select. Outside an access all selects are high.
- R3: When several enabled windows match, the lowest-numbered window wins.
- R4: An address that no enabled window matches uses chip select bit 5, 15 wait states and mode 0.
- R5: In each word cycle the active strobe (ext_rd_n or ext_wr_n) is low for exactly wait-states + 1 clock cycles.
- R6: Mode bit 0 adds one address setup cycle before the strobe. Mode bit 1 adds one recovery cycle after it. The chip select is low throughout, so each word cycle keeps it low for mode[0] + wait states + 1 + mode[1] cycles.
- R7: A narrow access runs one word cycle at the request address. A wide access runs two: first at the address, then at address + 2. Read data returns with the low word in cpu_rdata[15:0] and the high word in [31:16]; a narrow read returns zero in the upper half.
- R8: A write drives ext_dout with ext_doe high during its strobes: cpu_wdata[15:0] in the first word cycle and [31:16] in the second.
- R9: cpu_ready is a one-cycle pulse. Counting the accepting clock edge as 1, it is first seen after edge H*P + 1, where H is the number of word cycles and P is the per-word length from R6.
- R10: ext_hlda rises only after hold is requested and after the access in flight has fully ended. While it is high, ext_bus_en is low, all chip selects and strobes are inactive, ext_doe is low and no request is started.
- R11: ext_hlda falls one cycle after hold is released. A request held during the hold is then served.
- R12: Configuration writes to a window index of 5 or above have no effect. Window settings are captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window index |
| cfg_kind | input | 2 | 0 base, 1 mask, 2 control |
| cfg_wdata | input | 24 | Configuration value |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write |
| cpu_wide | input | 1 | 1 = 32-bit access |
| cpu_addr | input | 24 | Byte address (even) |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access complete pulse |
| cpu_rdata | output | 32 | Read data |
| ext_addr | output | 24 | External address |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | Data output enable |
| ext_din | input | 16 | External read data |
| ext_cs_n | output | 6 | Chip selects, bit 5 spare |
| ext_rd_n | output | 1 | Read strobe |
| ext_wr_n | output | 1 | Write strobe |
| ext_bus_en | output | 1 | Address and strobe drive enable |
| ext_hold | input | 1 | Bus request from external master |
| ext_hlda | output | 1 | Bus granted to external master |

## Verification
A corrupted wait counter shows up within the same word cycle as a strobe that is too short or too long. A wrong half flag shows on the second word's address or swaps the halves of the read data. A decode register latched at the wrong moment appears as the wrong chip select on the very first setup or strobe cycle. A sequencer that mishandles hold shows an acknowledge either while a chip select is still low or one cycle too late after release. Each of these faults is caught in the cycle it occurs, or by the ready pulse of that same access.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_RECOV, ST_DONE, ST_HOLD
  } ebc_state_e;

  localparam logic [1:0] KIND_BASE = 2'd0;
  localparam logic [1:0] KIND_MASK = 2'd1;
  localparam logic [1:0] KIND_CTRL = 2'd2;
endpackage

// File: rtl/ebc_range_regs.sv
module ebc_range_regs
  import ebc_pkg::*;
#(
  parameter int N   = 5,
  parameter int AW  = 24,
  parameter int WSW = 4,
  parameter int MW  = 2,
  parameter int IW  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [IW-1:0]           cfg_idx,
  input  logic [1:0]              cfg_kind,
  input  logic [AW-1:0]           cfg_wdata,
  output logic [N-1:0][AW-1:0]    base_o,
  output logic [N-1:0][AW-1:0]    mask_o,
  output logic [N-1:0]            en_o,
  output logic [N-1:0][WSW-1:0]   ws_o,
  output logic [N-1:0][MW-1:0]    mode_o
);
  // Window storage: one small register set per window, selected by index.
  for (genvar i = 0; i < N; i++) begin : g_win
    logic [AW-1:0]  base_r, mask_r;
    logic           en_r;
    logic [WSW-1:0] ws_r;
    logic [MW-1:0]  mode_r;
    wire            hit_w = cfg_we && (cfg_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_r <= '0;
        mask_r <= '0;
        en_r   <= 1'b0;
        ws_r   <= '0;
        mode_r <= '0;
      end else if (hit_w) begin
        case (cfg_kind)
          KIND_BASE: base_r <= cfg_wdata;
          KIND_MASK: mask_r <= cfg_wdata;
          KIND_CTRL: begin
            ws_r   <= cfg_wdata[WSW-1:0];
            mode_r <= cfg_wdata[WSW +: MW];
            en_r   <= cfg_wdata[WSW+MW];
          end
          default: ;
        endcase
      end
    end

    assign base_o[i] = base_r;
    assign mask_o[i] = mask_r;
    assign en_o[i]   = en_r;
    assign ws_o[i]   = ws_r;
    assign mode_o[i] = mode_r;
  end
endmodule

// File: rtl/ebc_decode.sv
module ebc_decode #(
  parameter int N   = 5,
  parameter int AW  = 24,
  parameter int WSW = 4,
  parameter int MW  = 2,
  parameter int IW  = 3
) (
  input  logic [AW-1:0]           addr_i,
  input  logic [N-1:0][AW-1:0]    base_i,
  input  logic [N-1:0][AW-1:0]    mask_i,
  input  logic [N-1:0]            en_i,
  input  logic [N-1:0][WSW-1:0]   ws_i,
  input  logic [N-1:0][MW-1:0]    mode_i,
  output logic [IW-1:0]           sel_o,
  output logic [WSW-1:0]          ws_o,
  output logic [MW-1:0]           mode_o
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = en_i[i] && (((addr_i ^ base_i[i]) & mask_i[i]) == '0);
  end

  // Scan from the top so the lowest matching index is the last written.
  always_comb begin
    sel_o  = IW'(N);
    ws_o   = '1;
    mode_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_o  = IW'(i);
        ws_o   = ws_i[i];
        mode_o = mode_i[i];
      end
    end
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int N   = 5,
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int WSW = 4,
  parameter int MW  = 2,
  parameter int IW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_wide,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [2*DW-1:0]   cpu_wdata,
  input  logic [IW-1:0]     dec_sel,
  input  logic [WSW-1:0]    dec_ws,
  input  logic [MW-1:0]     dec_mode,
  output logic              cpu_ready,
  output logic [2*DW-1:0]   cpu_rdata,
  output logic [AW-1:0]     ext_addr,
  output logic [DW-1:0]     ext_dout,
  output logic              ext_doe,
  input  logic [DW-1:0]     ext_din,
  output logic [N:0]        ext_cs_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic              ext_bus_en,
  input  logic              ext_hold,
  output logic              ext_hlda
);
  ebc_state_e     st_q, st_d;
  logic [WSW-1:0] cnt_q;
  logic           half_q, wide_q, we_q;
  logic [AW-1:0]  addr_q;
  logic [2*DW-1:0] wdata_q;
  logic [WSW-1:0] ws_q;
  logic [MW-1:0]  mode_q;
  logic [IW-1:0]  sel_q;
  logic [DW-1:0]  rlo_q, rhi_q;

  logic accept, last_half, strobe_end, half_end, n_active, n_half, n_we;
  logic [AW-1:0]   n_base;
  logic [2*DW-1:0] n_wdata;
  logic [IW-1:0]   n_sel;
  ebc_state_e      first_st;

  assign accept     = (st_q == ST_IDLE) && !ext_hold && cpu_req;
  assign last_half  = !wide_q || half_q;
  assign strobe_end = (st_q == ST_STROBE) && (cnt_q == '0);
  assign half_end   = (strobe_end && !mode_q[1]) || (st_q == ST_RECOV);
  assign first_st   = mode_q[0] ? ST_SETUP : ST_STROBE;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (ext_hold)     st_d = ST_HOLD;
        else if (cpu_req) st_d = dec_mode[0] ? ST_SETUP : ST_STROBE;
      end
      ST_SETUP:  st_d = ST_STROBE;
      ST_STROBE: begin
        if (cnt_q == '0) begin
          if (mode_q[1])      st_d = ST_RECOV;
          else if (last_half) st_d = ST_DONE;
          else                st_d = first_st;
        end
      end
      ST_RECOV: st_d = last_half ? ST_DONE : first_st;
      ST_DONE:  st_d = ext_hold ? ST_HOLD : ST_IDLE;
      ST_HOLD:  st_d = ext_hold ? ST_HOLD : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // View of the next cycle, used to register every pin one cycle ahead.
  always_comb begin
    n_half   = accept ? 1'b0 : ((half_end && !last_half) ? 1'b1 : half_q);
    n_base   = accept ? cpu_addr  : addr_q;
    n_we     = accept ? cpu_we    : we_q;
    n_wdata  = accept ? cpu_wdata : wdata_q;
    n_sel    = accept ? dec_sel   : sel_q;
    n_active = (st_d == ST_SETUP) || (st_d == ST_STROBE) || (st_d == ST_RECOV);
  end

  logic [AW-1:0] addr_r;
  logic [DW-1:0] dout_r;
  logic [N:0]    cs_r;
  logic          doe_r, rd_r, wr_r, en_r, hlda_r, rdy_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      wide_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ws_q    <= '0;
      mode_q  <= '0;
      sel_q   <= '0;
      rlo_q   <= '0;
      rhi_q   <= '0;
      addr_r  <= '0;
      dout_r  <= '0;
      cs_r    <= '1;
      doe_r   <= 1'b0;
      rd_r    <= 1'b1;
      wr_r    <= 1'b1;
      en_r    <= 1'b1;
      hlda_r  <= 1'b0;
      rdy_r   <= 1'b0;
    end else begin
      st_q   <= st_d;
      half_q <= n_half;
      if (accept) begin
        addr_q  <= cpu_addr;
        we_q    <= cpu_we;
        wide_q  <= cpu_wide;
        wdata_q <= cpu_wdata;
        ws_q    <= dec_ws;
        mode_q  <= dec_mode;
        sel_q   <= dec_sel;
        rlo_q   <= '0;
        rhi_q   <= '0;
      end
      if (st_d == ST_STROBE && (st_q != ST_STROBE || cnt_q == '0))
        cnt_q <= accept ? dec_ws : ws_q;
      else if (st_q == ST_STROBE)
        cnt_q <= cnt_q - WSW'(1);
      if (strobe_end && !we_q) begin
        if (half_q) rhi_q <= ext_din;
        else        rlo_q <= ext_din;
      end
      if (n_active) addr_r <= n_base + (n_half ? AW'(2) : AW'(0));
      dout_r <= n_half ? n_wdata[2*DW-1:DW] : n_wdata[DW-1:0];
      cs_r   <= '1;
      if (n_active) cs_r[n_sel] <= 1'b0;
      doe_r  <= n_active && n_we;
      rd_r   <= !((st_d == ST_STROBE) && !n_we);
      wr_r   <= !((st_d == ST_STROBE) && n_we);
      en_r   <= (st_d != ST_HOLD);
      hlda_r <= (st_d == ST_HOLD);
      rdy_r  <= (st_d == ST_DONE);
    end
  end

  assign cpu_ready  = rdy_r;
  assign cpu_rdata  = {rhi_q, rlo_q};
  assign ext_addr   = addr_r;
  assign ext_dout   = dout_r;
  assign ext_doe    = doe_r;
  assign ext_cs_n   = cs_r;
  assign ext_rd_n   = rd_r;
  assign ext_wr_n   = wr_r;
  assign ext_bus_en = en_r;
  assign ext_hlda   = hlda_r;
endmodule

// File: rtl/ebc_top.sv
module ebc_top #(
  parameter int N   = 5,
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int WSW = 4,
  parameter int MW  = 2,
  parameter int IW  = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [1:0]        cfg_kind,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_wide,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [2*DW-1:0]   cpu_wdata,
  output logic              cpu_ready,
  output logic [2*DW-1:0]   cpu_rdata,
  output logic [AW-1:0]     ext_addr,
  output logic [DW-1:0]     ext_dout,
  output logic              ext_doe,
  input  logic [DW-1:0]     ext_din,
  output logic [N:0]        ext_cs_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic              ext_bus_en,
  input  logic              ext_hold,
  output logic              ext_hlda
);
  logic [N-1:0][AW-1:0]  base, mask;
  logic [N-1:0]          en;
  logic [N-1:0][WSW-1:0] ws;
  logic [N-1:0][MW-1:0]  mode;
  logic [IW-1:0]         dec_sel;
  logic [WSW-1:0]        dec_ws;
  logic [MW-1:0]         dec_mode;

  ebc_range_regs #(.N(N), .AW(AW), .WSW(WSW), .MW(MW), .IW(IW)) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata),
    .base_o(base), .mask_o(mask), .en_o(en), .ws_o(ws), .mode_o(mode)
  );

  ebc_decode #(.N(N), .AW(AW), .WSW(WSW), .MW(MW), .IW(IW)) dec_i (
    .addr_i(cpu_addr), .base_i(base), .mask_i(mask), .en_i(en),
    .ws_i(ws), .mode_i(mode),
    .sel_o(dec_sel), .ws_o(dec_ws), .mode_o(dec_mode)
  );

  ebc_seq #(.N(N), .AW(AW), .DW(DW), .WSW(WSW), .MW(MW), .IW(IW)) seq_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wide(cpu_wide),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .dec_sel(dec_sel), .dec_ws(dec_ws), .dec_mode(dec_mode),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_din(ext_din), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_bus_en(ext_bus_en),
    .ext_hold(ext_hold), .ext_hlda(ext_hlda)
  );
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
  parameter int N = 5
) (
  input logic       clk,
  input logic       rst,
  input logic       cpu_ready,
  input logic       ext_hold,
  input logic       ext_hlda,
  input logic       ext_bus_en,
  input logic       ext_rd_n,
  input logic       ext_wr_n,
  input logic       ext_doe,
  input logic [N:0] ext_cs_n
);
  assert_cs_single_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_cs_n));

  assert_strobe_has_cs_R2: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> !(&ext_cs_n));

  assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));

  assert_write_drives_R8: assert property (@(posedge clk) disable iff (rst)
    !ext_wr_n |-> ext_doe);

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_grant_floats_R10: assert property (@(posedge clk) disable iff (rst)
    ext_hlda |-> (!ext_bus_en && (&ext_cs_n) && ext_rd_n && ext_wr_n && !ext_doe));

  assert_grant_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_hlda) |-> $past(ext_hold));

  assert_grant_release_R11: assert property (@(posedge clk) disable iff (rst)
    (ext_hlda && !ext_hold) |=> !ext_hlda);
endmodule

bind ebc_top ebc_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .ext_hold(ext_hold),
  .ext_hlda(ext_hlda), .ext_bus_en(ext_bus_en), .ext_rd_n(ext_rd_n),
  .ext_wr_n(ext_wr_n), .ext_doe(ext_doe), .ext_cs_n(ext_cs_n)
);

// File: tb/ebc_top_tb_top.sv
`timescale 1ns/100ps
module ebc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_kind = '0;
  logic [23:0] cfg_wdata = '0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_wide = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic [23:0] ext_addr;
  logic [15:0] ext_dout, ext_din;
  logic        ext_doe, ext_rd_n, ext_wr_n, ext_bus_en, ext_hlda;
  logic [5:0]  ext_cs_n;
  logic        ext_hold = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] memf(logic [23:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction
  assign ext_din = memf(ext_addr);

  ebc_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wide(cpu_wide),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_din(ext_din), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_bus_en(ext_bus_en),
    .ext_hold(ext_hold), .ext_hlda(ext_hlda)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench-side window model, written only for indices 0..4 (R12).
  logic [23:0] m_base [5];
  logic [23:0] m_mask [5];
  bit          m_en   [5];
  int          m_ws   [5];
  int          m_mode [5];

  task automatic cfg(int idx, int kind, logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_kind = 2'(kind); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 5) begin
      if (kind == 0) m_base[idx] = d;
      else if (kind == 1) m_mask[idx] = d;
      else if (kind == 2) begin
        m_ws[idx] = int'(d[3:0]); m_mode[idx] = int'(d[5:4]); m_en[idx] = d[6];
      end
    end
  endtask

  typedef struct {
    logic [23:0] a; bit we; bit wide; logic [31:0] d;
    int cs; int ws; int mode; string tag;
  } exp_t;
  exp_t q[$];

  function automatic exp_t make_exp(logic [23:0] a, bit we, bit wide,
                                    logic [31:0] d, string tag);
    exp_t e;
    e.a = a; e.we = we; e.wide = wide; e.d = d; e.tag = tag;
    e.cs = 5; e.ws = 15; e.mode = 0;
    for (int i = 4; i >= 0; i--)
      if (m_en[i] && ((a & m_mask[i]) == (m_base[i] & m_mask[i]))) begin
        e.cs = i; e.ws = m_ws[i]; e.mode = m_mode[i];
      end
    return e;
  endfunction

  function automatic int per_word(exp_t e);
    return (e.mode & 1) + e.ws + 1 + ((e.mode >> 1) & 1);
  endfunction

  // Driver: pushes the expected item, raises the request, checks latency (R9).
  task automatic do_access(logic [23:0] a, bit we, bit wide, logic [31:0] d, string tag);
    exp_t e;
    int n;
    e = make_exp(a, we, wide, d, tag);
    q.push_back(e);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_wide = wide; cpu_addr = a; cpu_wdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_ready && n < 200);
    cpu_req = 1'b0;
    check(n == (wide ? 2 : 1) * per_word(e) + 1, "R9", "ready latency",
          n, (wide ? 2 : 1) * per_word(e) + 1);
  endtask

  // Monitor: observes the bus pins and compares at each ready pulse.
  int act_cnt = 0, strb_cnt = 0, hcnt = 0, cs_idx = -1;
  bit cs_mix = 0, prev_strb = 0;
  logic [23:0] prev_addr = '0;
  logic [23:0] hadr [2];
  logic [15:0] hdat [2];

  always @(negedge clk) begin
    logic strb;
    exp_t e;
    int h, p;
    logic [31:0] exp_rd;
    if (!rst) begin
      strb = !ext_rd_n || !ext_wr_n;
      if (!(&ext_cs_n)) begin
        act_cnt++;
        for (int j = 0; j < 6; j++)
          if (!ext_cs_n[j]) begin
            if (cs_idx >= 0 && cs_idx != j) cs_mix = 1;
            cs_idx = j;
          end
      end
      if (strb) begin
        strb_cnt++;
        if ((!prev_strb || ext_addr != prev_addr) && hcnt < 2) begin
          hadr[hcnt] = ext_addr; hdat[hcnt] = ext_dout; hcnt++;
        end
      end
      prev_strb = strb;
      prev_addr = ext_addr;
      if (cpu_ready) begin
        if (q.size() == 0) begin
          check(0, "R9", "ready with nothing outstanding", 1, 0);
        end else begin
          e = q.pop_front();
          h = e.wide ? 2 : 1;
          p = per_word(e);
          check(cs_idx == e.cs && !cs_mix, e.tag, "chip select index", cs_idx, e.cs);
          check(act_cnt == h * p, "R6", "select-low cycles", act_cnt, h * p);
          check(strb_cnt == h * (e.ws + 1), "R5", "strobe cycles", strb_cnt, h * (e.ws + 1));
          check(hcnt == h, "R7", "word cycles", hcnt, h);
          check(hadr[0] == e.a, "R7", "first word address", hadr[0], e.a);
          if (e.wide) check(hadr[1] == e.a + 24'd2, "R7", "second word address", hadr[1], e.a + 24'd2);
          if (e.we) begin
            check(hdat[0] == e.d[15:0], "R8", "low write word", hdat[0], e.d[15:0]);
            if (e.wide) check(hdat[1] == e.d[31:16], "R8", "high write word", hdat[1], e.d[31:16]);
          end else begin
            exp_rd = e.wide ? {memf(e.a + 24'd2), memf(e.a)} : {16'h0, memf(e.a)};
            check(cpu_rdata == exp_rd, "R7", "read data", cpu_rdata, exp_rd);
          end
        end
        act_cnt = 0; strb_cnt = 0; hcnt = 0; cs_idx = -1; cs_mix = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired (all requirements): actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit quiet;
    exp_t e;
    for (int i = 0; i < 5; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_en[i] = 0; m_ws[i] = 0; m_mode[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(&ext_cs_n, "R2", "reset selects inactive", ext_cs_n, 6'h3f);
    check(ext_rd_n && ext_wr_n && !ext_doe, "R8", "reset strobes idle", {ext_rd_n, ext_wr_n, ext_doe}, 3'b110);
    check(!ext_hlda && ext_bus_en && !cpu_ready, "R10", "reset grant state",
          {ext_hlda, ext_bus_en, cpu_ready}, 3'b010);

    // R1: control word bits [3:0] ws, [5:4] mode, [6] enable.
    cfg(0, 0, 24'h010000); cfg(0, 1, 24'hFF0000); cfg(0, 2, 24'h40);
    cfg(1, 0, 24'h020000); cfg(1, 1, 24'hFF0000); cfg(1, 2, 24'h53);
    cfg(2, 0, 24'h030000); cfg(2, 1, 24'hFF0000); cfg(2, 2, 24'h62);
    cfg(3, 0, 24'h040000); cfg(3, 1, 24'hFF0000); cfg(3, 2, 24'h71);
    cfg(4, 0, 24'h000000); cfg(4, 1, 24'hF00000); cfg(4, 2, 24'h45);
    // R12: writes past the last window must not create a window.
    cfg(6, 0, 24'h800000); cfg(6, 1, 24'hFF0000); cfg(6, 2, 24'h40);

    do_access(24'h010010, 0, 0, 32'h0, "R1");
    do_access(24'h020020, 0, 1, 32'h0, "R6");
    do_access(24'h030040, 1, 1, 32'hCAFE1234, "R8");
    do_access(24'h040008, 1, 0, 32'hFFFF9876, "R6");
    do_access(24'h050000, 0, 0, 32'h0, "R1");
    do_access(24'h012340, 0, 0, 32'h0, "R3");
    do_access(24'h800000, 0, 1, 32'h0, "R4");
    do_access(24'h800010, 1, 0, 32'h0000BEEF, "R12");
    do_access(24'h010100, 0, 1, 32'h0, "R7");

    // R3/R1: disabling window 0 hands its addresses to window 4.
    cfg(0, 2, 24'h00);
    do_access(24'h010010, 0, 0, 32'h0, "R3");

    // R10: hold while idle.
    @(negedge clk); ext_hold = 1'b1;
    @(negedge clk);
    check(ext_hlda == 1'b1, "R10", "grant while idle", ext_hlda, 1);
    check(!ext_bus_en && (&ext_cs_n), "R10", "bus released", {ext_bus_en, ext_cs_n}, 7'h3f);
    e = make_exp(24'h020200, 0, 0, 32'h0, "R11");
    q.push_back(e);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_wide = 1'b0; cpu_addr = 24'h020200;
    quiet = 1;
    repeat (4) begin
      @(negedge clk);
      if (cpu_ready || !(&ext_cs_n) || !ext_hlda) quiet = 0;
    end
    check(quiet, "R10", "request held off during grant", !quiet, 0);
    ext_hold = 1'b0;
    @(negedge clk);
    check(ext_hlda == 1'b0, "R11", "grant drops after release", ext_hlda, 0);
    begin
      int n = 0;
      while (!cpu_ready && n < 200) begin @(negedge clk); n++; end
    end
    check(cpu_ready == 1'b1, "R11", "pending request served", cpu_ready, 1);
    cpu_req = 1'b0;

    // R10: hold raised in the first word of a split access.
    fork
      do_access(24'h020300, 0, 1, 32'h0, "R10");
      begin repeat (3) @(negedge clk); ext_hold = 1'b1; end
    join
    check(ext_hlda == 1'b0, "R10", "no grant before access ends", ext_hlda, 0);
    @(negedge clk);
    check(ext_hlda == 1'b1, "R10", "grant after access ends", ext_hlda, 1);
    ext_hold = 1'b0;
    @(negedge clk);
    check(ext_hlda == 1'b0, "R11", "grant released", ext_hlda, 0);

    do_access(24'h040020, 0, 1, 32'h0, "R2");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9", "all accesses completed", q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule